// File: doc/BRIEF.md
# Lowest-Priority Interrupt Redirection Table

This block keeps one task-priority record for each of sixteen interrupt-capable processor agents. It also picks the agent that should receive a redirectable interrupt. Two front-side buses carry task-priority update transactions. The block snoops both buses, and each update overwrites the record chosen by the agent index and one address bit. Each record holds:

- an enable bit,
- a 4-bit priority,
- an 8-bit physical ID,
- an 8-bit logical ID.

Record 0 also holds a global cluster-mode bit, which is written only by software.

When an interrupt must be redirected, the requester pulses `sel_req`. One clock later the block presents the physical and logical IDs of the enabled record with the numerically smallest priority. Software can read and write each record as a 32-bit word at byte offsets 80h to BCh through a simple register port.

Top module: `lpr_table`

## Requirements
- R1: After reset every record reads 0 through the register port, and `sel_vld`, `sel_none`, `sel_idx`, `sel_phys` and `sel_log` are 0.
- R2: When `busN_upd_vld` is high, record index {`busN_upd_agent`, `busN_upd_addr[3]`} is loaded as follows: priority from `busN_upd_prio`, physical ID from address bits 19:12, logical ID from address bits 11:4.
- R3: A bus update loads the enable bit with the level of `busN_upd_mask_n`, so a low level leaves the record disabled. A bus update never changes the cluster bit.
- R4: The register word for a record is laid out as:
  - bit 31: cluster
  - bit 23: enable
  - bits 19:16: priority
  - bits 15:8: physical ID
  - bits 7:0: logical ID

  Bits 30:24 and 22:20 always read 0.
- R5: A write with `sw_we` high to a word-aligned offset 80h + 4·i (i < 16) stores the enable, priority and ID fields of `sw_wdata` into record i on the next edge. Writes to any other offset, including unaligned ones, change no record. Reads from such offsets return 0.
- R6: The cluster bit can be set only in record 0, at offset 80h. In every other record, bit 31 reads 0.
- R7: For a request, the result is taken from the enabled record with the smallest priority value. When several records tie, the lowest index wins. `sel_idx`, `sel_phys` and `sel_log` report that record, and `sel_none` is 0.
- R8: If no record is enabled when the request is sampled, `sel_none` is 1, `sel_idx` is 0, and the IDs of record 0 are returned.
- R9: The result is registered. `sel_vld` is high exactly in the cycle after `sel_req` was high. The result reflects the table as it stood before any update in the request cycle. The result outputs hold their values while no request is made.
- R10: When several writers hit one record in the same cycle, the precedence is bus 1 over bus 0 over software.
- R11: Updates from the two buses to different records in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus0_upd_vld | input | 1 | Bus 0 update strobe |
| bus0_upd_agent | input | 3 | Bus 0 agent index (upper record index bits) |
| bus0_upd_addr | input | 17 | Bus 0 address bits 19:3 |
| bus0_upd_mask_n | input | 1 | Bus 0 active-low priority-disable attribute |
| bus0_upd_prio | input | 4 | Bus 0 priority attribute |
| bus1_upd_vld | input | 1 | Bus 1 update strobe |
| bus1_upd_agent | input | 3 | Bus 1 agent index |
| bus1_upd_addr | input | 17 | Bus 1 address bits 19:3 |
| bus1_upd_mask_n | input | 1 | Bus 1 active-low priority-disable attribute |
| bus1_upd_prio | input | 4 | Bus 1 priority attribute |
| sw_addr | input | 8 | Register byte offset |
| sw_we | input | 1 | Register write strobe |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Register read data (combinational) |
| sel_req | input | 1 | Redirection request |
| sel_vld | output | 1 | Result valid (one cycle after request) |
| sel_none | output | 1 | No enabled record existed |
| sel_idx | output | 4 | Index of the chosen record |
| sel_phys | output | 8 | Physical ID of the chosen record |
| sel_log | output | 8 | Logical ID of the chosen record |

## Verification
The bench builds the block with its default parameters: sixteen records, a three-bit agent index and base offset 80h. With these values the whole index space can be reached from both buses. This includes the top record and the edges of the address window at 7Ch and C0h. Because the table is small, ties, an empty table and same-cycle collisions between all three writers can all be set up directly. A long run with random stimulus then mixes requests with updates landing in the very cycle the request is sampled.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
  parameter int PRIO_W = 4;
  parameter int ID_W   = 8;

  typedef struct packed {
    logic              clus;
    logic              en;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   pid;
    logic [ID_W-1:0]   lid;
  } tpr_ent_t;

  // Register word layout: 31 cluster, 23 enable, 19:16 priority, 15:8 phys, 7:0 log
  function automatic logic [31:0] ent_to_word(tpr_ent_t e);
    logic [31:0] w;
    w        = '0;
    w[31]    = e.clus;
    w[23]    = e.en;
    w[19:16] = e.prio;
    w[15:8]  = e.pid;
    w[7:0]   = e.lid;
    return w;
  endfunction
endpackage

// File: rtl/lpr_upd_dec.sv
module lpr_upd_dec
  import lpr_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  logic                         vld,
  input  logic [$clog2(NUM_ENT)-2:0]   agent,
  input  logic [19:3]                  addr,
  input  logic                         mask_n,
  input  logic [PRIO_W-1:0]            prio,
  output logic [NUM_ENT-1:0]           hit,
  output tpr_ent_t                     val
);
  localparam int IDX_W = $clog2(NUM_ENT);

  logic [IDX_W-1:0] idx;
  assign idx = {agent, addr[3]};

  always_comb begin
    hit = '0;
    if (vld) hit[idx] = 1'b1;
    val.clus = 1'b0;
    val.en   = mask_n;
    val.prio = prio;
    val.pid  = addr[19:12];
    val.lid  = addr[11:4];
  end
endmodule

// File: rtl/lpr_entry_bank.sv
module lpr_entry_bank
  import lpr_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_ENT-1:0]         hit0,
  input  logic [NUM_ENT-1:0]         hit1,
  input  logic [NUM_ENT-1:0]         swhit,
  input  tpr_ent_t                   val0,
  input  tpr_ent_t                   val1,
  input  tpr_ent_t                   swval,
  output tpr_ent_t [NUM_ENT-1:0]     tab
);
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    tpr_ent_t q, d;
    logic     ld;

    assign ld = hit0[i] | hit1[i] | swhit[i];

    // precedence: bus 1 over bus 0 over software
    always_comb begin
      d = q;
      if (swhit[i]) begin
        d = swval;
        if (i != 0) d.clus = 1'b0;
      end
      if (hit0[i]) begin
        d      = val0;
        d.clus = q.clus;
      end
      if (hit1[i]) begin
        d      = val1;
        d.clus = q.clus;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
    end

    assign tab[i] = q;
  end
endmodule

// File: rtl/lpr_min_sel.sv
module lpr_min_sel
  import lpr_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  tpr_ent_t [NUM_ENT-1:0]       tab,
  output logic                         found,
  output logic [$clog2(NUM_ENT)-1:0]   idx
);
  localparam int IDX_W = $clog2(NUM_ENT);

  logic [PRIO_W-1:0] best;

  // strict compare keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (tab[i].en && (!found || tab[i].prio < best)) begin
        found = 1'b1;
        best  = tab[i].prio;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lpr_table.sv
module lpr_table
  import lpr_pkg::*;
#(
  parameter int NUM_ENT  = 16,
  parameter int ADDR_W   = 8,
  parameter int BASE_OFF = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus0_upd_vld,
  input  logic [$clog2(NUM_ENT)-2:0]    bus0_upd_agent,
  input  logic [19:3]                   bus0_upd_addr,
  input  logic                          bus0_upd_mask_n,
  input  logic [3:0]                    bus0_upd_prio,
  input  logic                          bus1_upd_vld,
  input  logic [$clog2(NUM_ENT)-2:0]    bus1_upd_agent,
  input  logic [19:3]                   bus1_upd_addr,
  input  logic                          bus1_upd_mask_n,
  input  logic [3:0]                    bus1_upd_prio,
  input  logic [ADDR_W-1:0]             sw_addr,
  input  logic                          sw_we,
  input  logic [31:0]                   sw_wdata,
  output logic [31:0]                   sw_rdata,
  input  logic                          sel_req,
  output logic                          sel_vld,
  output logic                          sel_none,
  output logic [$clog2(NUM_ENT)-1:0]    sel_idx,
  output logic [7:0]                    sel_phys,
  output logic [7:0]                    sel_log
);
  localparam int IDX_W  = $clog2(NUM_ENT);
  localparam int SPAN   = 4 * NUM_ENT;

  tpr_ent_t [NUM_ENT-1:0] tab;
  tpr_ent_t               val0, val1, swval;
  logic [NUM_ENT-1:0]     hit0, hit1, swhit;

  lpr_upd_dec #(.NUM_ENT(NUM_ENT)) u_dec0 (
    .vld(bus0_upd_vld), .agent(bus0_upd_agent), .addr(bus0_upd_addr),
    .mask_n(bus0_upd_mask_n), .prio(bus0_upd_prio), .hit(hit0), .val(val0)
  );

  lpr_upd_dec #(.NUM_ENT(NUM_ENT)) u_dec1 (
    .vld(bus1_upd_vld), .agent(bus1_upd_agent), .addr(bus1_upd_addr),
    .mask_n(bus1_upd_mask_n), .prio(bus1_upd_prio), .hit(hit1), .val(val1)
  );

  // software register port decode
  logic             sw_in;
  logic [IDX_W-1:0] sw_idx;
  logic             unused_sw;

  always_comb begin
    sw_in  = (int'(sw_addr) >= BASE_OFF) && (int'(sw_addr) < BASE_OFF + SPAN)
             && (sw_addr[1:0] == 2'b00);
    sw_idx = IDX_W'((int'(sw_addr) - BASE_OFF) >> 2);
    swhit  = '0;
    if (sw_we && sw_in) swhit[sw_idx] = 1'b1;
    swval.clus = sw_wdata[31];
    swval.en   = sw_wdata[23];
    swval.prio = sw_wdata[19:16];
    swval.pid  = sw_wdata[15:8];
    swval.lid  = sw_wdata[7:0];
  end

  assign unused_sw = ^{sw_wdata[30:24], sw_wdata[22:20]};
  assign sw_rdata  = sw_in ? ent_to_word(tab[sw_idx]) : '0;

  lpr_entry_bank #(.NUM_ENT(NUM_ENT)) u_bank (
    .clk(clk), .rst_n(rst_n), .hit0(hit0), .hit1(hit1), .swhit(swhit),
    .val0(val0), .val1(val1), .swval(swval), .tab(tab)
  );

  // selection
  logic             min_found;
  logic [IDX_W-1:0] min_idx;
  logic             none_d;
  logic [IDX_W-1:0] idx_d;
  logic [7:0]       phys_d, log_d;

  lpr_min_sel #(.NUM_ENT(NUM_ENT)) u_sel (
    .tab(tab), .found(min_found), .idx(min_idx)
  );

  always_comb begin
    none_d = ~min_found;
    idx_d  = min_found ? min_idx : '0;
    phys_d = tab[idx_d].pid;
    log_d  = tab[idx_d].lid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_vld  <= 1'b0;
      sel_none <= 1'b0;
      sel_idx  <= '0;
      sel_phys <= '0;
      sel_log  <= '0;
    end else begin
      sel_vld <= sel_req;
      if (sel_req) begin
        sel_none <= none_d;
        sel_idx  <= idx_d;
        sel_phys <= phys_d;
        sel_log  <= log_d;
      end
    end
  end
endmodule

// File: rtl/lpr_table_chk.sv
module lpr_table_chk
  import lpr_pkg::*;
#(
  parameter int NUM_ENT  = 16,
  parameter int ADDR_W   = 8,
  parameter int BASE_OFF = 128
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sel_req,
  input logic                         sel_vld,
  input logic                         sel_none,
  input logic [$clog2(NUM_ENT)-1:0]   sel_idx,
  input logic [7:0]                   sel_phys,
  input logic [7:0]                   sel_log,
  input logic [ADDR_W-1:0]            sw_addr,
  input logic [31:0]                  sw_rdata,
  input tpr_ent_t [NUM_ENT-1:0]       tab
);
  logic [NUM_ENT-1:0] en_now, en_q;

  always_comb
    for (int i = 0; i < NUM_ENT; i++) en_now[i] = tab[i].en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_now;
  end

  // R9
  sel_vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req |=> sel_vld);
  // R9
  sel_vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_req |=> !sel_vld);
  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_req |=> ($stable(sel_phys) && $stable(sel_log) && $stable(sel_idx) && $stable(sel_none)));
  // R7
  sel_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vld && !sel_none) |-> en_q[sel_idx]);
  // R8
  sel_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vld && sel_none) |-> (en_q == '0 && sel_idx == '0));
  // R8
  sel_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_vld && en_q != '0) |-> !sel_none);
  // R4
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata[30:24] == 7'd0 && sw_rdata[22:20] == 3'd0));
  // R6
  clus_only0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sw_addr) != BASE_OFF) |-> !sw_rdata[31]);
endmodule

bind lpr_table lpr_table_chk #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sel_vld(sel_vld), .sel_none(sel_none),
  .sel_idx(sel_idx), .sel_phys(sel_phys), .sel_log(sel_log), .sw_addr(sw_addr),
  .sw_rdata(sw_rdata), .tab(tab)
);

// File: tb/sim_lpr_table.sv
module sim_lpr_table;
  localparam int N = 16;

  logic        clk, rst_n;
  logic        b0_vld, b1_vld, b0_mask_n, b1_mask_n;
  logic [2:0]  b0_agent, b1_agent;
  logic [19:3] b0_addr, b1_addr;
  logic [3:0]  b0_prio, b1_prio;
  logic [7:0]  sw_addr;
  logic        sw_we;
  logic [31:0] sw_wdata, sw_rdata;
  logic        sel_req, sel_vld, sel_none;
  logic [3:0]  sel_idx;
  logic [7:0]  sel_phys, sel_log;

  int checks = 0, errors = 0;
  bit done = 0;

  lpr_table u0 (
    .clk(clk), .rst_n(rst_n),
    .bus0_upd_vld(b0_vld), .bus0_upd_agent(b0_agent), .bus0_upd_addr(b0_addr),
    .bus0_upd_mask_n(b0_mask_n), .bus0_upd_prio(b0_prio),
    .bus1_upd_vld(b1_vld), .bus1_upd_agent(b1_agent), .bus1_upd_addr(b1_addr),
    .bus1_upd_mask_n(b1_mask_n), .bus1_upd_prio(b1_prio),
    .sw_addr(sw_addr), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .sel_req(sel_req), .sel_vld(sel_vld), .sel_none(sel_none), .sel_idx(sel_idx),
    .sel_phys(sel_phys), .sel_log(sel_log)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // behavioural reference model
  bit m_en[N];
  int m_pr[N], m_pid[N], m_lid[N];
  bit m_cl;
  bit e_vld, e_none;
  int e_idx, e_pid, e_lid;
  int best, bi, k;
  bit fnd;

  function automatic bit in_win(int a);
    return a >= 128 && a < 128 + 4 * N && (a % 4) == 0;
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] w;
    int j;
    w = '0;
    if (in_win(a)) begin
      j        = (a - 128) / 4;
      w[31]    = (j == 0) ? m_cl : 1'b0;
      w[23]    = m_en[j];
      w[19:16] = 4'(m_pr[j]);
      w[15:8]  = 8'(m_pid[j]);
      w[7:0]   = 8'(m_lid[j]);
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_en[i] = 0; m_pr[i] = 0; m_pid[i] = 0; m_lid[i] = 0;
      end
      m_cl = 0; e_vld = 0; e_none = 0; e_idx = 0; e_pid = 0; e_lid = 0;
    end else begin
      e_vld = sel_req;
      if (sel_req) begin
        fnd = 0; best = 99; bi = 0;
        for (int i = 0; i < N; i++)
          if (m_en[i] && m_pr[i] < best) begin fnd = 1; best = m_pr[i]; bi = i; end
        e_none = !fnd;
        e_idx  = bi;
        e_pid  = m_pid[bi];
        e_lid  = m_lid[bi];
      end
      if (sw_we && in_win(int'(sw_addr))) begin
        k = (int'(sw_addr) - 128) / 4;
        m_en[k] = sw_wdata[23]; m_pr[k] = int'(sw_wdata[19:16]);
        m_pid[k] = int'(sw_wdata[15:8]); m_lid[k] = int'(sw_wdata[7:0]);
        if (k == 0) m_cl = sw_wdata[31];
      end
      if (b0_vld) begin
        k = int'({b0_agent, b0_addr[3]});
        m_en[k] = b0_mask_n; m_pr[k] = int'(b0_prio);
        m_pid[k] = int'(b0_addr[19:12]); m_lid[k] = int'(b0_addr[11:4]);
      end
      if (b1_vld) begin
        k = int'({b1_agent, b1_addr[3]});
        m_en[k] = b1_mask_n; m_pr[k] = int'(b1_prio);
        m_pid[k] = int'(b1_addr[19:12]); m_lid[k] = int'(b1_addr[11:4]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("R9 sel_vld", 32'(sel_vld), 32'(e_vld));
      chk("R8 sel_none", 32'(sel_none), 32'(e_none));
      chk("R7 sel_idx", 32'(sel_idx), 32'(e_idx));
      chk("R7 sel_phys", 32'(sel_phys), 32'(e_pid));
      chk("R7 sel_log", 32'(sel_log), 32'(e_lid));
      chk("R4 sw_rdata", sw_rdata, m_read(int'(sw_addr)));
    end
  end

  task automatic clr();
    b0_vld = 0; b1_vld = 0; sw_we = 0; sel_req = 0;
  endtask

  task automatic nxt();
    @(negedge clk);
    clr();
  endtask

  task automatic upd(input int b, input int ent, input bit on, input int pr, input int pid, input int lid);
    if (b == 0) begin
      b0_vld = 1; b0_agent = 3'(ent >> 1); b0_addr = {8'(pid), 8'(lid), 1'(ent)};
      b0_mask_n = on; b0_prio = 4'(pr);
    end else begin
      b1_vld = 1; b1_agent = 3'(ent >> 1); b1_addr = {8'(pid), 8'(lid), 1'(ent)};
      b1_mask_n = on; b1_prio = 4'(pr);
    end
  endtask

  task automatic swr(input int a, input logic [31:0] d);
    sw_we = 1; sw_addr = 8'(a); sw_wdata = d;
  endtask

  task automatic read_all();
    for (int i = 0; i < N; i++) begin nxt(); sw_addr = 8'(128 + 4 * i); end
  endtask

  initial begin
    rst_n = 0; clr();
    b0_agent = 0; b1_agent = 0; b0_addr = 0; b1_addr = 0;
    b0_mask_n = 0; b1_mask_n = 0; b0_prio = 0; b1_prio = 0;
    sw_addr = 8'h80; sw_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset contents
    read_all();
    // R8: empty table returns record 0
    nxt(); sel_req = 1;
    nxt();
    // R2 R11: both buses, distinct records
    nxt(); upd(0, 5, 1, 7, 8'hA5, 8'h3C); upd(1, 15, 1, 9, 8'h11, 8'hEE);
    nxt(); upd(0, 2, 1, 3, 8'h22, 8'h44); sel_req = 1;
    nxt(); sel_req = 1;
    // R7: tie at priority 3, lowest index wins
    nxt(); upd(1, 9, 1, 3, 8'h99, 8'h90);
    nxt(); sel_req = 1;
    // R3: disable the winner via the active-low attribute
    nxt(); upd(0, 2, 0, 1, 8'h01, 8'h02);
    nxt(); sel_req = 1;
    read_all();
    // R5 R4 R6: software writes, reserved bits, cluster bit
    nxt(); swr(8'h8C, 32'hFFFF_FFFF);
    nxt(); swr(8'h80, 32'hFFFF_FFFF);
    nxt(); swr(8'hBC, 32'h0080_0D0E);
    nxt(); swr(8'h7C, 32'h0080_0000);
    nxt(); swr(8'hC0, 32'h0080_0000);
    nxt(); swr(8'h85, 32'h0080_0000);
    read_all();
    nxt(); sel_req = 1;
    // R3: bus update keeps cluster bit of record 0
    nxt(); upd(0, 0, 1, 4, 8'h10, 8'h20); sw_addr = 8'h80;
    nxt(); sel_req = 1;
    // R10: all three writers on record 6, then bus0 and software only
    nxt(); swr(8'h98, 32'h0080_0111); upd(0, 6, 1, 2, 8'h66, 8'h06); upd(1, 6, 1, 5, 8'h77, 8'h07);
    nxt(); sw_addr = 8'h98;
    nxt(); swr(8'h98, 32'h0080_0222); upd(0, 6, 1, 0, 8'h55, 8'h05);
    nxt(); sw_addr = 8'h98; sel_req = 1;
    // R9: request together with an update of the current winner
    nxt(); sel_req = 1; upd(1, 6, 0, 0, 8'h00, 8'h00);
    nxt(); sel_req = 1;
    nxt();
    // R8: disable everything
    for (int i = 0; i < N; i++) begin nxt(); upd(0, i, 0, i, i, 255 - i); end
    nxt(); sel_req = 1;
    nxt();
    // random mix (R2 R5 R7 R10 R11)
    for (int c = 0; c < 3000; c++) begin
      nxt();
      if ($urandom_range(3) == 0)
        upd(0, int'($urandom_range(N - 1)), 1'($urandom_range(3) != 0), int'($urandom_range(15)),
            int'($urandom_range(255)), int'($urandom_range(255)));
      if ($urandom_range(3) == 0)
        upd(1, int'($urandom_range(N - 1)), 1'($urandom_range(3) != 0), int'($urandom_range(15)),
            int'($urandom_range(255)), int'($urandom_range(255)));
      sw_addr = 8'(120 + $urandom_range(76));
      if ($urandom_range(5) == 0) begin sw_we = 1; sw_wdata = $urandom; end
      sel_req = 1'($urandom_range(1));
    end
    nxt();
    nxt();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule